// File: doc/BRIEF.md
# Stack Pointer Control Unit

This unit holds the stack pointer of a small 8-bit processor core. After reset the pointer holds the top address of internal SRAM, and the stack grows toward lower addresses. The core's decoder drives strobes into the unit. A single-byte push writes at the current pointer and then decrements it. A single-byte pop increments the pointer first and reads at the new value. Call and interrupt-entry strobes start a short sequence that stores a return address of two or three bytes, one byte per cycle. Return strobes undo that sequence. The unit drives the data-memory address and the read and write strobes for each of these accesses.

Software reaches the pointer as two byte registers on an I/O bus. A write to the low byte opens a short window in which interrupts are held off. This lets the high byte be written before an interrupt can use a half-updated pointer. Each retired instruction shortens the window, and any other I/O write closes it. A written value that falls at or below the SRAM floor raises an error flag for one cycle.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer equals SRAM_TOP (default 0x3FFF), and `busy`, `irq_inhibit` and `sp_err` are low.
- R2: An accepted `push_stb` raises `stk_we` in the same cycle with `stk_addr` equal to the pointer. The pointer is one lower after the clock edge.
- R3: An accepted `pop_stb` raises `stk_re` in the same cycle with `stk_addr` equal to the pointer plus one. The pointer is one higher after the clock edge.
- R4: `call_stb` starts RET_BYTES (default 2) write cycles, beginning the cycle after the strobe. The addresses start at the pointer and descend by one each cycle. The pointer ends RET_BYTES lower, and `busy` is high during exactly those cycles.
- R5: `ret_stb` starts RET_BYTES read cycles at ascending addresses, starting at the pointer plus one. The pointer ends RET_BYTES higher.
- R6: All four stack strobes are ignored while `busy` is high. When several arrive together, only one is taken, in the order call, return, push, pop.
- R7: With `io_addr` at LO_ADDR (0x3D), `io_rdata` shows pointer bits 7:0. At HI_ADDR (0x3E) it shows bits 15:8. Any other address reads 0.
- R8: An I/O write to LO_ADDR or HI_ADDR replaces that byte. In the same cycle it overrides a push or pop, which is then dropped with no memory strobe. A write to any other address leaves the pointer unchanged.
- R9: A write to LO_ADDR raises `irq_inhibit`. It stays high until GUARD_INSNS (default 4) `retire_stb` pulses have been seen.
- R10: Any I/O write other than to LO_ADDR, including HI_ADDR, clears `irq_inhibit` at the next edge. A new LO_ADDR write reloads the full window.
- R11: `sp_err` is high for one cycle after an I/O write that leaves the pointer at or below FLOOR_ADDR (default 0x2000). A write that leaves it above that value raises no error.
- R12: `stk_we` and `stk_re` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| io_addr | input | IO_AW | I/O register address |
| io_we | input | 1 | I/O write strobe, any address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data for the addressed pointer byte |
| push_stb | input | 1 | Single-byte push |
| pop_stb | input | 1 | Single-byte pop |
| call_stb | input | 1 | Call or interrupt entry: push the return address |
| ret_stb | input | 1 | Return or return from interrupt: pop the return address |
| retire_stb | input | 1 | One instruction retired |
| stk_addr | output | ADDR_W | Data-memory address of the stack access |
| stk_we | output | 1 | Stack byte write this cycle |
| stk_re | output | 1 | Stack byte read this cycle |
| busy | output | 1 | Return-address sequence in progress |
| irq_inhibit | output | 1 | Interrupts must not be taken |
| sp_err | output | 1 | Last software write put the pointer at or below the floor |

## Verification
The bench targets strobes that arrive together or during a return-address sequence. A design with the wrong priority, or one that accepts strobes while busy, makes an extra memory access that the scoreboard reports, and it leaves the pointer at the wrong value. Every access is checked against its expected address. Off-by-one errors in the pre-increment or post-decrement therefore show up, as does an ascending call order or a wrong sequence length.

The interrupt window is checked against its exact retire count and against a reload partway through. It is also checked against being closed by a high-byte write or by a write to an unrelated register. The floor check is tested exactly at 0x2000, so a strict compare instead of an inclusive one is reported.

// File: rtl/stack_ptr_pkg.sv
package stack_ptr_pkg;

  // direction of a return-address sequence
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } seq_dir_e;

endpackage

// File: rtl/stack_ret_seq.sv
module stack_ret_seq
  import stack_ptr_pkg::*;
#(
  parameter int RET_BYTES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_dn,
  input  logic     start_up,
  input  logic     hold,
  output logic     busy,
  output logic     step,
  output seq_dir_e dir
);

  localparam int CW = $clog2(RET_BYTES + 1);
  localparam logic [CW-1:0] LOAD = CW'(RET_BYTES);

  logic [CW-1:0] cnt_q, cnt_d;
  seq_dir_e      dir_q, dir_d;
  logic          seq_en;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (cnt_q == '0) begin
      if (start_dn) begin
        cnt_d = LOAD;
        dir_d = DIR_DOWN;
      end else if (start_up) begin
        cnt_d = LOAD;
        dir_d = DIR_UP;
      end
    end else if (!hold) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  assign seq_en = (cnt_d != cnt_q) || (dir_d != dir_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= DIR_DOWN;
    end else if (seq_en) begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign busy = (cnt_q != '0);
  assign step = busy && !hold;
  assign dir  = dir_q;

  // R4
  seq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD);

  // R6
  busy_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !hold) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/stack_irq_guard.sv
module stack_irq_guard #(
  parameter int GUARD_INSNS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lo_wr,
  input  logic any_wr,
  input  logic retire,
  output logic inhibit
);

  localparam int CW = $clog2(GUARD_INSNS + 1);
  localparam logic [CW-1:0] LOAD = CW'(GUARD_INSNS);

  logic [CW-1:0] win_q, win_d;
  logic          win_en;

  always_comb begin
    win_d = win_q;
    if (lo_wr) begin
      win_d = LOAD;
    end else if (any_wr) begin
      win_d = '0;
    end else if (retire && (win_q != '0)) begin
      win_d = win_q - CW'(1);
    end
  end

  assign win_en = (win_d != win_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else if (win_en) begin
      win_q <= win_d;
    end
  end

  assign inhibit = (win_q != '0);

  // R9
  lo_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |=> inhibit);

  // R10
  other_wr_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && !lo_wr) |=> !inhibit);

  // R9
  retire_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !any_wr && inhibit) |=> (win_q == $past(win_q) - CW'(1)));

endmodule

// File: rtl/stack_io_regs.sv
module stack_io_regs #(
  parameter int               ADDR_W  = 16,
  parameter int               IO_AW   = 6,
  parameter logic [IO_AW-1:0] LO_ADDR = 6'h3D,
  parameter logic [IO_AW-1:0] HI_ADDR = 6'h3E
) (
  input  logic [IO_AW-1:0]  io_addr,
  input  logic              io_we,
  input  logic [7:0]        io_wdata,
  input  logic [ADDR_W-1:0] sp_q,
  output logic              lo_wr,
  output logic              hi_wr,
  output logic [ADDR_W-1:0] wr_val,
  output logic [7:0]        rdata
);

  logic [15:0] sp16;
  logic [15:0] wr16;

  assign sp16  = 16'(sp_q);
  assign lo_wr = io_we && (io_addr == LO_ADDR);
  assign hi_wr = io_we && (io_addr == HI_ADDR);

  always_comb begin
    wr16 = sp16;
    if (lo_wr) begin
      wr16 = {sp16[15:8], io_wdata};
    end else if (hi_wr) begin
      wr16 = {io_wdata, sp16[7:0]};
    end
  end

  assign wr_val = ADDR_W'(wr16);

  always_comb begin
    if (io_addr == LO_ADDR) begin
      rdata = sp16[7:0];
    end else if (io_addr == HI_ADDR) begin
      rdata = sp16[15:8];
    end else begin
      rdata = 8'h00;
    end
  end

endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import stack_ptr_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] SRAM_TOP    = 16'h3FFF,
  parameter logic [ADDR_W-1:0] FLOOR_ADDR  = 16'h2000,
  parameter int                RET_BYTES   = 2,
  parameter int                GUARD_INSNS = 4,
  parameter int                IO_AW       = 6,
  parameter logic [IO_AW-1:0]  LO_ADDR     = 6'h3D,
  parameter logic [IO_AW-1:0]  HI_ADDR     = 6'h3E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic              io_we,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              push_stb,
  input  logic              pop_stb,
  input  logic              call_stb,
  input  logic              ret_stb,
  input  logic              retire_stb,
  output logic [ADDR_W-1:0] stk_addr,
  output logic              stk_we,
  output logic              stk_re,
  output logic              busy,
  output logic              irq_inhibit,
  output logic              sp_err
);

  logic [ADDR_W-1:0] sp_q, sp_d;
  logic              sp_en;
  logic              lo_wr, hi_wr, sw_wr;
  logic [ADDR_W-1:0] wr_val;
  logic              seq_busy, seq_step;
  seq_dir_e          seq_dir;
  logic              start_dn, start_up;
  logic              push_acc, pop_acc;
  logic              err_q, err_d;

  stack_io_regs #(
    .ADDR_W (ADDR_W),
    .IO_AW  (IO_AW),
    .LO_ADDR(LO_ADDR),
    .HI_ADDR(HI_ADDR)
  ) u_io (
    .io_addr (io_addr),
    .io_we   (io_we),
    .io_wdata(io_wdata),
    .sp_q    (sp_q),
    .lo_wr   (lo_wr),
    .hi_wr   (hi_wr),
    .wr_val  (wr_val),
    .rdata   (io_rdata)
  );

  assign sw_wr = lo_wr || hi_wr;

  // strobe acceptance: call > ret > push > pop, nothing while busy
  assign start_dn = call_stb && !seq_busy;
  assign start_up = ret_stb && !call_stb && !seq_busy;
  assign push_acc = push_stb && !call_stb && !ret_stb && !seq_busy && !sw_wr;
  assign pop_acc  = pop_stb && !push_stb && !call_stb && !ret_stb &&
                    !seq_busy && !sw_wr;

  stack_ret_seq #(
    .RET_BYTES(RET_BYTES)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_dn(start_dn),
    .start_up(start_up),
    .hold    (sw_wr),
    .busy    (seq_busy),
    .step    (seq_step),
    .dir     (seq_dir)
  );

  stack_irq_guard #(
    .GUARD_INSNS(GUARD_INSNS)
  ) u_guard (
    .clk    (clk),
    .rst_n  (rst_n),
    .lo_wr  (lo_wr),
    .any_wr (io_we),
    .retire (retire_stb),
    .inhibit(irq_inhibit)
  );

  assign stk_we   = push_acc || (seq_step && (seq_dir == DIR_DOWN));
  assign stk_re   = pop_acc || (seq_step && (seq_dir == DIR_UP));
  assign stk_addr = stk_re ? (sp_q + ADDR_W'(1)) : sp_q;
  assign busy     = seq_busy;

  always_comb begin
    sp_d = sp_q;
    if (sw_wr) begin
      sp_d = wr_val;
    end else if (stk_we) begin
      sp_d = sp_q - ADDR_W'(1);
    end else if (stk_re) begin
      sp_d = sp_q + ADDR_W'(1);
    end
  end

  assign sp_en = sw_wr || stk_we || stk_re;
  assign err_d = sw_wr && (wr_val <= FLOOR_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= SRAM_TOP;
    end else if (sp_en) begin
      sp_q <= sp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign sp_err = err_q;

  // R2
  push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_we && !busy) |=> (sp_q == $past(sp_q) - ADDR_W'(1)));

  // R3
  pop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_re && !busy) |=> (sp_q == $past(sp_q) + ADDR_W'(1)));

  // R8
  sw_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> (sp_q == $past(wr_val)));

  // R11
  err_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_err |-> $past(sw_wr));

  // R12
  no_dual_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_we && stk_re));

endmodule

// File: tb/stack_ptr_unit_test.sv
module stack_ptr_unit_test;

  localparam logic [5:0] LO = 6'h3D;
  localparam logic [5:0] HI = 6'h3E;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  io_addr;
  logic        io_we;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata;
  logic        push_stb, pop_stb, call_stb, ret_stb, retire_stb;
  logic [15:0] stk_addr;
  logic        stk_we, stk_re, busy, irq_inhibit, sp_err;

  int checks = 0;
  int fails  = 0;
  logic [16:0] expq[$];

  always #5 clk = ~clk;

  stack_ptr_unit uut (
    .clk(clk), .rst_n(rst_n),
    .io_addr(io_addr), .io_we(io_we), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .push_stb(push_stb), .pop_stb(pop_stb), .call_stb(call_stb),
    .ret_stb(ret_stb), .retire_stb(retire_stb),
    .stk_addr(stk_addr), .stk_we(stk_we), .stk_re(stk_re),
    .busy(busy), .irq_inhibit(irq_inhibit), .sp_err(sp_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: every stack access must match the next expected item
  always @(negedge clk) begin
    if (rst_n === 1'b1 && (stk_we || stk_re)) begin
      if (expq.size() == 0) begin
        check("R6/R8 unexpected stack access", {15'b0, stk_we, stk_addr}, 32'h0);
      end else begin
        logic [16:0] e;
        e = expq.pop_front();
        check("R2/R3/R4/R5 stack access {we,addr}", {15'b0, stk_we, stk_addr}, {15'b0, e});
      end
    end
  end

  task automatic strobe(input bit pu, input bit po, input bit ca, input bit re);
    @(posedge clk); #1;
    push_stb = pu; pop_stb = po; call_stb = ca; ret_stb = re;
    @(posedge clk); #1;
    push_stb = 0; pop_stb = 0; call_stb = 0; ret_stb = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic io_write(input logic [5:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    io_addr = a; io_wdata = d; io_we = 1;
    @(posedge clk); #1;
    io_we = 0; io_addr = 6'h00;
  endtask

  task automatic retire_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; retire_stb = 1;
      @(posedge clk); #1; retire_stb = 0;
    end
  endtask

  task automatic check_sp(input string req, input logic [15:0] exp);
    logic [15:0] v;
    io_addr = LO; #1; v[7:0] = io_rdata;
    io_addr = HI; #1; v[15:8] = io_rdata;
    io_addr = 6'h00;
    check(req, {16'h0, v}, {16'h0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 0; io_addr = 0; io_we = 0; io_wdata = 0;
    push_stb = 0; pop_stb = 0; call_stb = 0; ret_stb = 0; retire_stb = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 irq_inhibit", irq_inhibit, 0);
    check("R1 sp_err", sp_err, 0);
    check_sp("R1 pointer", 16'h3FFF);
    // R7 unrelated address reads zero
    io_addr = 6'h10; #1;
    check("R7 other address read", io_rdata, 8'h00);

    // R2 push
    expq.push_back({1'b1, 16'h3FFF});
    strobe(1, 0, 0, 0);
    check_sp("R2 pointer after push", 16'h3FFE);

    // R6 push and pop together: push wins
    expq.push_back({1'b1, 16'h3FFE});
    strobe(1, 1, 0, 0);
    check_sp("R6 push beats pop", 16'h3FFD);

    // R3 pop
    expq.push_back({1'b0, 16'h3FFE});
    strobe(0, 1, 0, 0);
    check_sp("R3 pointer after pop", 16'h3FFE);

    // R4 call sequence and busy window
    expq.push_back({1'b1, 16'h3FFE});
    expq.push_back({1'b1, 16'h3FFD});
    strobe(0, 0, 1, 0);
    @(negedge clk); check("R4 busy first byte", busy, 1);
    @(posedge clk); #1;
    @(negedge clk); check("R4 busy second byte", busy, 1);
    @(posedge clk); #1;
    @(negedge clk); check("R4 busy released", busy, 0);
    check_sp("R4 pointer after call", 16'h3FFC);

    // R5 return sequence
    expq.push_back({1'b0, 16'h3FFD});
    expq.push_back({1'b0, 16'h3FFE});
    strobe(0, 0, 0, 1);
    wait_idle();
    check_sp("R5 pointer after return", 16'h3FFE);

    // R6 push held during busy is ignored
    expq.push_back({1'b1, 16'h3FFE});
    expq.push_back({1'b1, 16'h3FFD});
    strobe(0, 0, 1, 0);
    push_stb = 1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    push_stb = 0;
    wait_idle();
    check_sp("R6 push ignored while busy", 16'h3FFC);

    // R6 call beats return
    expq.push_back({1'b1, 16'h3FFC});
    expq.push_back({1'b1, 16'h3FFB});
    strobe(0, 0, 1, 1);
    wait_idle();
    check_sp("R6 call beats return", 16'h3FFA);
    expq.push_back({1'b0, 16'h3FFB});
    expq.push_back({1'b0, 16'h3FFC});
    strobe(0, 0, 0, 1);
    wait_idle();
    check_sp("R5 second return", 16'h3FFC);

    // R8 software write beats push: no access
    @(posedge clk); #1;
    io_addr = HI; io_wdata = 8'h30; io_we = 1; push_stb = 1;
    @(posedge clk); #1;
    io_we = 0; push_stb = 0; io_addr = 6'h00;
    @(negedge clk);
    check_sp("R8 write overrides push", 16'h30FC);

    // R9 low write opens the window for four retires
    io_write(LO, 8'h80);
    @(negedge clk);
    check("R9 inhibit after low write", irq_inhibit, 1);
    check_sp("R8 low byte write", 16'h3080);
    retire_n(3);
    @(negedge clk);
    check("R9 inhibit after three retires", irq_inhibit, 1);
    retire_n(1);
    @(negedge clk);
    check("R9 inhibit after four retires", irq_inhibit, 0);

    // R10 high write closes the window
    io_write(LO, 8'h80);
    io_write(HI, 8'h31);
    @(negedge clk);
    check("R10 high write closes window", irq_inhibit, 0);
    check_sp("R8 high byte write", 16'h3180);

    // R10 unrelated write closes it, pointer untouched
    io_write(LO, 8'h80);
    io_write(6'h10, 8'h55);
    @(negedge clk);
    check("R10 other write closes window", irq_inhibit, 0);
    check_sp("R8 other write keeps pointer", 16'h3180);

    // R10 reload
    io_write(LO, 8'h11);
    retire_n(2);
    io_write(LO, 8'h22);
    retire_n(3);
    @(negedge clk);
    check("R10 reload keeps window open", irq_inhibit, 1);
    retire_n(1);
    @(negedge clk);
    check("R10 reloaded window expires", irq_inhibit, 0);

    // R11 floor check
    io_write(HI, 8'h20);
    @(negedge clk);
    check("R11 0x2022 no error", sp_err, 0);
    io_write(LO, 8'h00);
    @(negedge clk);
    check("R11 0x2000 flags error", sp_err, 1);
    @(negedge clk);
    check("R11 error lasts one cycle", sp_err, 0);
    io_write(HI, 8'h1F);
    @(negedge clk);
    check("R11 0x1F00 flags error", sp_err, 1);

    // R2 push from software-set pointer
    io_write(HI, 8'h25);
    expq.push_back({1'b1, 16'h2500});
    strobe(1, 0, 0, 0);
    check_sp("R2 push after write", 16'h24FF);

    repeat (3) @(negedge clk);
    check("R4/R12 no missing accesses", expq.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule